// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

The block produces eight edge-aligned pulse-width-modulated outputs from one shared up-counter. The counter starts at a programmable start value and reloads it after reaching a programmable modulo value, so every channel runs with the same period. The counter is advanced by a tick that comes from one of three sources, passed through a power-of-two prescaler. The sources are the system clock, a fixed-rate pulse input, or an asynchronous external clock that is synchronised and edge-detected. All of this runs on one system clock through synchronous enables; no derived clocks are made.

Each channel holds a compare value and drives its active level while the counter is below that value. A per-channel polarity bit inverts the channel. A per-channel mask bit and a per-channel enable bit can each force the output to a programmable idle level. A lock bit guards the clock source, prescaler and modulo fields against stray writes. Software configures the block through a flat word-addressed register port with combinational read data.

Top module: `pwm8_timer`

## Requirements
- R1: After reset the counter is 0 and stopped, the modulo is 0xFFFF, the start value, idle levels, polarity, channel enables, compare values and lock are 0, and the mask register (address 5) reads 0xFF, so every output shows its idle level 0.
- R2: The source field, at bits [4:3] of the control register (address 0), picks the count source. 0 stops the counter, which then holds its value. 1 counts on every system clock. 2 counts on each cycle with `fix_tick` high. 3 counts once per rising edge of `ext_clk`, which is seen after a two-stage synchroniser.
- R3: The prescale field, at bits [2:0] of the control register, makes the counter advance once per 2^p source pulses, for p from 0 to 7.
- R4: On each advance the counter adds one. When it advances at the modulo value (address 2), it reloads the start value (address 3) instead, so the period is modulo minus start plus one advances.
- R5: An unmasked, enabled channel with polarity 0 drives 1 while the counter is below its active compare value and 0 otherwise. A compare of 0 therefore gives a constant 0, and a compare above the modulo gives a constant 1.
- R6: A compare write (address 8+n for channel n) goes to a buffer. While the counter runs, the buffer becomes active at the next reload. While the counter is stopped, it becomes active one cycle after the write.
- R7: Polarity bit n (address 6) inverts the level of unmasked, enabled channel n.
- R8: When mask bit n (address 5) is 1, output n equals bit n of the idle-level register (address 4), whatever the counter, compare and polarity are.
- R9: Channel enable bit n sits at bit 16+n of the control register. When it is 0, output n shows its idle level even if its mask bit is 0.
- R10: Writing 1 to bit 0 of the lock register (address 7) sets the lock. Writing bit 1 with bit 0 clear releases it, and bit 0 reads the lock state. While locked, writes leave the modulo, source and prescale fields unchanged, but the control write still updates the channel enables.
- R11: Every register reads back at its address. Address 1 returns the live counter, and compare addresses return the buffered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fix_tick | input | 1 | Fixed-rate count pulse, synchronous to clk |
| ext_clk | input | 1 | Asynchronous external count clock |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 24 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 24 | Register read data for reg_addr |
| pwm_out | output | 8 | Channel outputs |

## Verification
The channels are given compare values of zero, inside the period, equal to modulo plus one and above it. This separates the constant-low, pulsing and constant-high cases and shows any off-by-one at the compare edge. The same settings are run from the system clock at several prescale values, from an irregular pseudo-random `fix_tick` stream, and from a slow external clock, which tells apart the source selection, the synchroniser delay and the prescaler reset. A compare is rewritten in the middle of a period, which exposes an early or late shadow load. The mask, enable and polarity settings, and writes made with the lock set or released, show which register fields the lock guards.

// File: rtl/pwm8_pkg.sv
// Shared constants and types for the eight-channel PWM timer.
// Assumes word addressing on a narrow register port.
package pwm8_pkg;
    localparam int PS_W         = 3;
    localparam int SEL_W        = 2;
    localparam int CTRL_PS_LSB  = 0;
    localparam int CTRL_SEL_LSB = 3;
    localparam int CTRL_EN_LSB  = 16;

    localparam int A_CTRL  = 0;
    localparam int A_COUNT = 1;
    localparam int A_MOD   = 2;
    localparam int A_START = 3;
    localparam int A_INIT  = 4;
    localparam int A_MASK  = 5;
    localparam int A_POL   = 6;
    localparam int A_PROT  = 7;
    localparam int A_CMP0  = 8;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } src_e;
endpackage

// File: rtl/pwm8_regs.sv
// Register file: configuration storage, write lock and read mux.
// Assumes one access per cycle; reads are combinational on addr.
module pwm8_regs
    import pwm8_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          we,
    input  logic [CNT_W-1:0]              count,
    output src_e                          src_sel,
    output logic [PS_W-1:0]               prescale,
    output logic [CNT_W-1:0]              modulo,
    output logic [CNT_W-1:0]              start,
    output logic [NUM_CH-1:0]             init_lvl,
    output logic [NUM_CH-1:0]             mask,
    output logic [NUM_CH-1:0]             pol,
    output logic [NUM_CH-1:0]             ch_en,
    output logic                          lock,
    output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_buf,
    output logic [DATA_W-1:0]             rdata
);
    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(A_COUNT);
    localparam logic [ADDR_W-1:0] AD_MOD   = ADDR_W'(A_MOD);
    localparam logic [ADDR_W-1:0] AD_START = ADDR_W'(A_START);
    localparam logic [ADDR_W-1:0] AD_INIT  = ADDR_W'(A_INIT);
    localparam logic [ADDR_W-1:0] AD_MASK  = ADDR_W'(A_MASK);
    localparam logic [ADDR_W-1:0] AD_POL   = ADDR_W'(A_POL);
    localparam logic [ADDR_W-1:0] AD_PROT  = ADDR_W'(A_PROT);

    // Register writes, with the lock guarding source, prescale and modulo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel  <= SRC_OFF;
            prescale <= '0;
            modulo   <= '1;
            start    <= '0;
            init_lvl <= '0;
            mask     <= '1;
            pol      <= '0;
            ch_en    <= '0;
            lock     <= 1'b0;
            cmp_buf  <= '0;
        end else if (we) begin
            case (addr)
                AD_CTRL: begin
                    ch_en <= wdata[CTRL_EN_LSB +: NUM_CH];
                    if (!lock) begin
                        src_sel  <= src_e'(wdata[CTRL_SEL_LSB +: SEL_W]);
                        prescale <= wdata[CTRL_PS_LSB +: PS_W];
                    end
                end
                AD_MOD:   if (!lock) modulo <= wdata[CNT_W-1:0];
                AD_START: start    <= wdata[CNT_W-1:0];
                AD_INIT:  init_lvl <= wdata[NUM_CH-1:0];
                AD_MASK:  mask     <= wdata[NUM_CH-1:0];
                AD_POL:   pol      <= wdata[NUM_CH-1:0];
                AD_PROT: begin
                    if (wdata[0])      lock <= 1'b1;
                    else if (wdata[1]) lock <= 1'b0;
                end
                default: ;
            endcase
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(A_CMP0 + i)) cmp_buf[i] <= wdata[CNT_W-1:0];
            end
        end
    end

    // Read mux for the addressed register.
    always_comb begin
        rdata = '0;
        case (addr)
            AD_CTRL: begin
                rdata[CTRL_EN_LSB +: NUM_CH] = ch_en;
                rdata[CTRL_SEL_LSB +: SEL_W] = src_sel;
                rdata[CTRL_PS_LSB +: PS_W]   = prescale;
            end
            AD_COUNT: rdata[CNT_W-1:0]  = count;
            AD_MOD:   rdata[CNT_W-1:0]  = modulo;
            AD_START: rdata[CNT_W-1:0]  = start;
            AD_INIT:  rdata[NUM_CH-1:0] = init_lvl;
            AD_MASK:  rdata[NUM_CH-1:0] = mask;
            AD_POL:   rdata[NUM_CH-1:0] = pol;
            AD_PROT:  rdata[0]          = lock;
            default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(A_CMP0 + i)) rdata[CNT_W-1:0] = cmp_buf[i];
        end
    end
endmodule

// File: rtl/pwm8_tickgen.sv
// Count-enable generator: source select, external clock synchroniser,
// edge detector and power-of-two prescaler, all on the system clock.
// Assumes fix_tick is already synchronous to clk.
module pwm8_tickgen
    import pwm8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  src_e            src_sel,
    input  logic [PS_W-1:0] prescale,
    input  logic            fix_tick,
    input  logic            ext_clk,
    output logic            tick,
    output logic            running
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [SYNC_STAGES:0] ext_sync;
    logic                 ext_rise;
    logic                 src_pulse;
    logic [DIV_W-1:0]     div_cnt;
    logic [DIV_W-1:0]     div_mask;

    // Synchroniser plus one extra stage for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[SYNC_STAGES-1:0], ext_clk};
    end

    assign ext_rise = ext_sync[SYNC_STAGES-1] & ~ext_sync[SYNC_STAGES];
    assign running  = (src_sel != SRC_OFF);

    // Pick the raw pulse of the selected source.
    always_comb begin
        case (src_sel)
            SRC_SYS: src_pulse = 1'b1;
            SRC_FIX: src_pulse = fix_tick;
            SRC_EXT: src_pulse = ext_rise;
            default: src_pulse = 1'b0;
        endcase
    end

    // Terminal value of the prescaler: 2^prescale - 1.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) div_mask[i] = (i < int'(prescale));
    end

    assign tick = running & src_pulse & (div_cnt >= div_mask);

    // Prescaler: count source pulses, clear on tick or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) div_cnt <= '0;
        else if (src_pulse)     div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end
endmodule

// File: rtl/pwm8_counter.sv
// Shared period counter: advances on tick, reloads start after modulo.
// Assumes software keeps start at or below modulo.
module pwm8_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] modulo,
    input  logic [CNT_W-1:0] start,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = tick & (count == modulo);

    // Advance or reload the counter on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (wrap) count <= start;
        else if (tick) count <= count + 1'b1;
    end
endmodule

// File: rtl/pwm8_channel.sv
// One output channel: shadowed compare, edge-aligned compare, polarity
// and masking. Assumes the buffered compare comes from the register file.
module pwm8_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cmp_next,
    input  logic             pol,
    input  logic             masked,
    input  logic             init_lvl,
    input  logic [CNT_W-1:0] count,
    output logic             out,
    output logic [CNT_W-1:0] cmp_act
);
    // Load the active compare at reload, or at once while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                cmp_act <= '0;
        else if (!running || wrap) cmp_act <= cmp_next;
    end

    assign out = masked ? init_lvl : ((count < cmp_act) ^ pol);
endmodule

// File: rtl/pwm8_timer.sv
// Top level: eight PWM channels sharing one counter and one register port.
// Assumes a single system clock and synchronous active-low reset.
module pwm8_timer
    import pwm8_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 24,
    parameter int HAS_CH_EN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fix_tick,
    input  logic              ext_clk,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    src_e                         src_sel;
    logic [PS_W-1:0]              prescale;
    logic [CNT_W-1:0]             modulo;
    logic [CNT_W-1:0]             start;
    logic [CNT_W-1:0]             count;
    logic [NUM_CH-1:0]            init_lvl;
    logic [NUM_CH-1:0]            mask;
    logic [NUM_CH-1:0]            pol;
    logic [NUM_CH-1:0]            ch_en;
    logic [NUM_CH-1:0]            en_eff;
    logic [NUM_CH-1:0]            mask_eff;
    logic                         lock;
    logic                         tick;
    logic                         running;
    logic                         wrap;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;

    pwm8_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
        .count(count), .src_sel(src_sel), .prescale(prescale), .modulo(modulo),
        .start(start), .init_lvl(init_lvl), .mask(mask), .pol(pol), .ch_en(ch_en),
        .lock(lock), .cmp_buf(cmp_buf), .rdata(reg_rdata)
    );

    pwm8_tickgen u_tick (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .prescale(prescale),
        .fix_tick(fix_tick), .ext_clk(ext_clk), .tick(tick), .running(running)
    );

    pwm8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .modulo(modulo), .start(start),
        .count(count), .wrap(wrap)
    );

    // Per-channel enables exist only in the variant that has them.
    if (HAS_CH_EN != 0) begin : g_en
        assign en_eff = ch_en;
    end else begin : g_no_en
        assign en_eff = '1;
    end

    assign mask_eff = mask | ~en_eff;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm8_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .running(running), .wrap(wrap),
            .cmp_next(cmp_buf[i]), .pol(pol[i]), .masked(mask_eff[i]),
            .init_lvl(init_lvl[i]), .count(count), .out(pwm_out[i]),
            .cmp_act(cmp_act[i])
        );
    end
endmodule

// File: rtl/pwm8_timer_chk.sv
// Property checker for the PWM timer, attached to the top by bind.
// Assumes visibility of the top's internal counter and control nets.
module pwm8_timer_chk
    import pwm8_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input logic                    wrap,
    input logic                    running,
    input logic                    lock,
    input logic                    reg_we,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [CNT_W-1:0]        count,
    input logic [CNT_W-1:0]        modulo,
    input logic [CNT_W-1:0]        start,
    input logic [NUM_CH-1:0]       pwm_out,
    input logic [NUM_CH-1:0]       init_lvl,
    input logic [NUM_CH-1:0]       mask_eff,
    input logic [NUM_CH*CNT_W-1:0] cmp_act
);
    a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(count));

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == $past(start)));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (count == CNT_W'($past(count) + 1'b1)));

    a_r10_mod_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && reg_we && reg_addr == ADDR_W'(A_MOD)) |=> $stable(modulo));

    a_r8_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (((pwm_out ^ init_lvl) & mask_eff) == '0));

    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> $stable(cmp_act));
endmodule

bind pwm8_timer pwm8_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .running(running),
    .lock(lock), .reg_we(reg_we), .reg_addr(reg_addr), .count(count),
    .modulo(modulo), .start(start), .pwm_out(pwm_out), .init_lvl(init_lvl),
    .mask_eff(mask_eff), .cmp_act(cmp_act)
);

// File: tb/pwm8_timer_test.sv
// Self-checking bench with a behavioural cycle model compared every clock.
module pwm8_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fix_tick = 1'b0;
    logic        ext_clk = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    wire  [23:0] reg_rdata;
    wire  [7:0]  pwm_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Behavioural model state.
    int       m_cnt = 0, m_mod = 'hFFFF, m_start = 0, m_sel = 0, m_ps = 0, m_pre = 0;
    bit [7:0] m_init = 0, m_mask = 8'hFF, m_pol = 0, m_en = 0;
    bit       m_lock = 0, s1 = 0, s2 = 0, s3 = 0;
    int       m_buf[8];
    int       m_act[8];

    logic [15:0] lfsr = 16'hACE1;
    int          ext_ctr = 0;

    pwm8_timer uut (
        .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_clk(ext_clk),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [7:0] exp_out();
        bit [7:0] v;
        for (int n = 0; n < 8; n++) begin
            if (m_en[n] && !m_mask[n]) v[n] = (m_cnt < m_act[n]) ^ m_pol[n];
            else                       v[n] = m_init[n];
        end
        return v;
    endfunction

    function automatic int model_rd(int a);
        case (a)
            0: return (int'(m_en) << 16) | (m_sel << 3) | m_ps;
            1: return m_cnt;
            2: return m_mod;
            3: return m_start;
            4: return int'(m_init);
            5: return int'(m_mask);
            6: return int'(m_pol);
            7: return int'(m_lock);
            default: return m_buf[a - 8];
        endcase
    endfunction

    function automatic int ctrl(int en, int sel, int ps);
        return (en << 16) | (sel << 3) | ps;
    endfunction

    // Cycle model of the requirements, updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mod = 'hFFFF; m_start = 0; m_sel = 0; m_ps = 0; m_pre = 0;
            m_init = 0; m_mask = 8'hFF; m_pol = 0; m_en = 0; m_lock = 0;
            s1 = 0; s2 = 0; s3 = 0;
            for (int n = 0; n < 8; n++) begin m_buf[n] = 0; m_act[n] = 0; end
        end else begin
            bit run, src, tk, wr;
            int pm;
            run = (m_sel != 0);
            case (m_sel)
                1: src = 1'b1;
                2: src = fix_tick;
                3: src = s2 && !s3;
                default: src = 1'b0;
            endcase
            pm = (1 << m_ps) - 1;
            tk = run && src && (m_pre >= pm);
            wr = tk && (m_cnt == m_mod);
            for (int n = 0; n < 8; n++) if (!run || wr) m_act[n] = m_buf[n];
            if (!run)     m_pre = 0;
            else if (src) m_pre = tk ? 0 : m_pre + 1;
            if (tk) m_cnt = wr ? m_start : ((m_cnt + 1) & 'hFFFF);
            s3 = s2; s2 = s1; s1 = ext_clk;
            if (reg_we) begin
                case (int'(reg_addr))
                    0: begin
                        m_en = reg_wdata[23:16];
                        if (!m_lock) begin m_sel = reg_wdata[4:3]; m_ps = reg_wdata[2:0]; end
                    end
                    2: if (!m_lock) m_mod = reg_wdata[15:0];
                    3: m_start = reg_wdata[15:0];
                    4: m_init = reg_wdata[7:0];
                    5: m_mask = reg_wdata[7:0];
                    6: m_pol = reg_wdata[7:0];
                    7: begin
                        if (reg_wdata[0])      m_lock = 1'b1;
                        else if (reg_wdata[1]) m_lock = 1'b0;
                    end
                    default: m_buf[int'(reg_addr) - 8] = reg_wdata[15:0];
                endcase
            end
        end
    end

    // Every-cycle output comparison against the model.
    always @(negedge clk) begin
        if (cmp_on && !done) check("R5 R7 R8 R9 outputs", int'(pwm_out), int'(exp_out()));
    end

    // Source stimulus: pseudo-random fixed pulses and a slow external clock.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        fix_tick = lfsr[0] & lfsr[3];
        ext_ctr++;
        if (ext_ctr >= 3) begin ext_ctr = 0; ext_clk = ~ext_clk; end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_addr = 4'(a);
        reg_wdata = 24'(d);
        reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rdx(int a, string req);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        check(req, int'(reg_rdata), model_rd(a));
    endtask

    task automatic rdv(int a, int exp, string req);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1: reset values at the ports.
        #1 check("R1 outputs idle", int'(pwm_out), 0);
        rdv(5, 'hFF, "R1 mask");
        rdv(2, 'hFFFF, "R1 modulo");
        rdv(1, 0, "R1 count");
        rdv(0, 0, "R1 ctrl");
        rdv(7, 0, "R1 lock");
        idle(5);
        rdv(1, 0, "R2 stopped count holds");

        // Configuration while stopped.
        wr(2, 9);
        wr(8, 3); wr(9, 0); wr(10, 12); wr(11, 10); wr(12, 5);
        wr(13, 9); wr(14, 1); wr(15, 6);
        wr(5, 0);
        wr(4, 'hA5);
        idle(1);
        #1 check("R9 enables clear force idle", int'(pwm_out), 'hA5);
        wr(4, 0);
        wr(0, ctrl('hFF, 1, 0));
        idle(3);
        rdx(1, "R4 count");

        // R5: constant levels for compare 0 and compare above modulo.
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            check("R5 compare 0 low", int'(pwm_out[1]), 0);
            check("R5 compare 12 high", int'(pwm_out[2]), 1);
            check("R5 compare mod+1 high", int'(pwm_out[3]), 1);
        end
        rdx(1, "R4 count");

        // R6: compare rewrite mid-period waits for the reload.
        wr(8, 7);
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            check("R6 shadow timing", int'(pwm_out[0]), int'(m_cnt < m_act[0]));
        end
        rdx(8, "R6 R11 compare buffer");

        // R7: polarity.
        wr(6, 'h0F);
        idle(25);
        rdx(6, "R7 R11 polarity");
        wr(6, 0);

        // R3: prescaler at several settings.
        wr(0, ctrl('hFF, 1, 2));
        idle(60);
        rdx(1, "R3 prescale 2");
        wr(0, ctrl('hFF, 1, 7));
        idle(600);
        rdx(1, "R3 prescale 7");
        wr(0, ctrl('hFF, 1, 1));
        idle(40);
        rdx(1, "R3 prescale 1");

        // R2: fixed-pulse and external sources.
        wr(0, ctrl('hFF, 2, 0));
        idle(150);
        rdx(1, "R2 fixed source");
        wr(0, ctrl('hFF, 3, 0));
        idle(200);
        rdx(1, "R2 external source");
        wr(0, ctrl('hFF, 3, 1));
        idle(200);
        rdx(1, "R2 R3 external with prescale");

        // R10: write lock.
        wr(7, 1);
        rdv(7, 1, "R10 lock set");
        wr(2, 3);
        rdv(2, 9, "R10 modulo locked");
        wr(0, ctrl('h0F, 1, 0));
        rdv(0, ctrl('h0F, 3, 1), "R10 ctrl locked fields");
        idle(60);
        wr(7, 2);
        rdv(7, 0, "R10 lock released");
        wr(2, 4);
        rdv(2, 4, "R10 modulo unlocked");
        wr(0, ctrl('hFF, 1, 0));
        idle(30);

        // R8: mask with nonzero idle levels.
        wr(4, 'hA5);
        wr(5, 'h3C);
        idle(30);
        rdx(5, "R8 R11 mask");
        rdx(4, "R11 idle levels");

        // R4: nonzero start value.
        wr(2, 6);
        wr(3, 2);
        idle(40);
        rdx(1, "R4 start reload");
        rdx(3, "R11 start");

        // R2: stop holds the counter.
        wr(0, ctrl('hFF, 0, 0));
        @(negedge clk);
        reg_addr = 4'(1);
        #1 held = int'(reg_rdata);
        idle(12);
        rdv(1, held, "R2 stop holds");

        idle(3);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule